// File: doc/BRIEF.md
# General-Purpose Pin Controller with Edge Interrupts

This block sits on a 32-bit single-word memory-mapped slave bus and manages a parameterizable set of general-purpose pins (1 to 32, default 16). Software can read the sampled pin levels. It sets the output levels and the per-pin output enables. It can hand individual pins over to an alternate on-chip source. It can arm per-pin edge detection that ends in a single interrupt line.

Pin levels are sampled on every system clock by default. Through a control bit, they can instead be captured on edges of an external capture clock. That clock is brought into the system domain through a synchronizer, and software picks whether its rising or its falling edge triggers the capture. Only full-word accesses are accepted: any access with a byte-select pattern other than all ones ends with the error response and changes nothing. Pad cells, tri-state drivers and bus arbitration live outside.

Top module: `gpio_ctrl`

## Requirements
- R1: `NPINS` sets the pin count (1 to 32). Every pin register is `NPINS` bits wide. Bits at and above `NPINS` always read as zero, and writes to them are dropped.
- R2: Registers are selected by address bits 4:2. The mapping is: 0 sampled input (read-only), 1 output data, 2 output enable, 3 interrupt enable, 4 trigger polarity, 5 alternate-source select, 6 control. Offset 7 reads zero.
- R3: With `FULL_DECODE`=1, an access reaches a register only if address bits 1:0 and every address bit above bit 4 are zero. Any other address is acknowledged, reads zero and writes nothing. With `FULL_DECODE`=0, only bits 4:2 are decoded.
- R4: An access whose byte selects are not all ones gets a one-cycle `bus_err` instead of `bus_ack`, never both, and writes no register.
- R5: A full-word request is answered by a registered `bus_ack`, one cycle after the request is first presented. The acknowledge lasts exactly one cycle, and the read data is valid in that cycle.
- R6: Control register bits are: bit 0 external capture enable, bit 1 falling-edge capture select, bit 2 interrupt output enable, bit 3 interrupt status (read, clear-only).
- R7: With bit 0 clear, the input register loads `pin_i` on every clock. With bit 0 set, it loads `pin_i` only on a synchronized rising edge of `ext_clk`, or on a falling edge when bit 1 is set. A pin change with no such edge leaves it unchanged.
- R8: The status bit sets when a pin with its interrupt-enable bit set shows, in the input register, a rising edge (polarity bit 1) or a falling edge (polarity bit 0). It stays set until software writes the control register with bit 3 at 0. Writing 1 leaves it unchanged, and a new edge in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when the status bit is set and control bit 2 is set. Status remains readable while bit 2 is clear.
- R10: Each `pin_o` bit follows `aux_i` when its alternate-select bit is 1 and the output data bit otherwise. `pin_oe` equals the output-enable register.
- R11: A register whose bit in `IMPL_MASK` (bit index = register offset) is 0 reads as zero and ignores writes. An omitted alternate-select register leaves every pin on output data.
- R12: Synchronous reset clears every register, the status bit, `bus_ack`, `bus_err`, `irq_o` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADR_W | Byte address |
| bus_sel | input | 4 | Byte selects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Normal completion |
| bus_err | output | 1 | Error completion (narrow access) |
| irq_o | output | 1 | Interrupt request |
| ext_clk | input | 1 | External capture clock |
| aux_i | input | NPINS | Alternate output sources |
| pin_i | input | NPINS | Pin input levels |
| pin_o | output | NPINS | Pin output levels |
| pin_oe | output | NPINS | Pin output enables |

## Verification
The bench targets partial byte selects. A design that wrote on them, or answered with both ack and err, would corrupt the output data that is read back afterwards. It drives addresses that differ only above bit 4 or in the byte-offset bits. A full decoder that aliased them would overwrite the output register, while the partial-decode instance is expected to accept them. It exercises clear-only status writes, edges on disabled pins, and both trigger polarities. A swapped polarity or a status bit that could be set by software would show up on `irq_o`. It also toggles pins without capture-clock edges and swaps the capture edge. A block that ignored the external-clock mode, or captured on the wrong edge, would read back the wrong input word.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int BUS_W    = 32;
    localparam int NUM_REGS = 7;
    localparam int SEL_LO   = 2;
    localparam int SEL_HI   = 4;

    // Register index decoded from address bits 4:2 (order is the map)
    typedef enum logic [2:0] {
        RS_IN   = 3'd0,
        RS_OUT  = 3'd1,
        RS_OE   = 3'd2,
        RS_IEN  = 3'd3,
        RS_POL  = 3'd4,
        RS_ALT  = 3'd5,
        RS_CTL  = 3'd6,
        RS_NONE = 3'd7
    } reg_sel_e;

    // Control word as read back, bit 0 at the bottom
    typedef struct packed {
        logic stat;
        logic irq_en;
        logic fall_sel;
        logic ext_sel;
    } ctl_t;

    // One decoded bus request
    typedef struct packed {
        logic     take;
        logic     wr;
        logic     hit;
        reg_sel_e idx;
    } bus_op_t;

    function automatic logic edge_match(input logic cur, input logic prv, input logic rise_sel);
        return rise_sel ? (cur & ~prv) : (~cur & prv);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
`timescale 1ns/1ps
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int ADR_W       = 8,
    parameter bit FULL_DECODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [ADR_W-1:0] adr,
    input  logic [3:0]       sel,
    output bus_op_t          op,
    output logic             ack,
    output logic             err
);

    logic pend;
    logic whole;
    logic addr_ok;
    logic unused_adr;

    assign unused_adr = ^adr;

    generate
        if (FULL_DECODE) begin : g_full
            assign addr_ok = (adr[ADR_W-1:SEL_HI+1] == '0) && (adr[SEL_LO-1:0] == '0);
        end else begin : g_part
            assign addr_ok = 1'b1;
        end
    endgenerate

    assign pend  = cyc & stb & ~ack & ~err;
    assign whole = &sel;

    always_comb begin
        op.take = pend & whole;
        op.idx  = reg_sel_e'(adr[SEL_HI:SEL_LO]);
        op.hit  = addr_ok & (op.idx != RS_NONE);
        op.wr   = op.take & we & op.hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            err <= 1'b0;
        end else begin
            ack <= pend & whole;
            err <= pend & ~whole;
        end
    end

endmodule

// File: rtl/gpio_in_capture.sv
`timescale 1ns/1ps
module gpio_in_capture #(
    parameter int N           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_clk,
    input  logic         ext_sel,
    input  logic         fall_sel,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] smp_q
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic             ref_clk;
    logic [CHAIN-1:0] chain_q;
    logic             tick;

    // Falling-edge capture = rising edge of the inverted clock
    assign ref_clk = ext_clk ^ fall_sel;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN-2:0], ref_clk};
    end

    assign tick = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    always_ff @(posedge clk) begin
        if (rst)                  smp_q <= '0;
        else if (!ext_sel || tick) smp_q <= pin_i;
    end

endmodule

// File: rtl/gpio_irq_gen.sv
`timescale 1ns/1ps
module gpio_irq_gen
    import gpio_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] smp,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] pol,
    input  logic         clr_wr,
    output logic         any_hit,
    output logic         stat_q
);

    logic [N-1:0] prev_q;
    logic [N-1:0] hit_vec;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= smp;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_pin
            assign hit_vec[g] = ien[g] & edge_match(smp[g], prev_q[g], pol[g]);
        end
    endgenerate

    assign any_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 1'b0;
        else     stat_q <= any_hit | (stat_q & ~clr_wr);
    end

endmodule

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int                    NPINS       = 16,
    parameter int                    ADR_W       = 8,
    parameter bit                    FULL_DECODE = 1'b1,
    parameter logic [NUM_REGS-1:0]   IMPL_MASK   = 7'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_adr,
    input  logic [3:0]       bus_sel,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_ack,
    output logic             bus_err,
    output logic             irq_o,
    input  logic             ext_clk,
    input  logic [NPINS-1:0] aux_i,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] pin_oe
);

    localparam int N        = NPINS;
    localparam int FIRST_RW = 1;
    localparam int LAST_RW  = 5;

    bus_op_t          op;
    logic [N-1:0]     wdat;
    logic [N-1:0]     dreg [FIRST_RW:LAST_RW];
    logic [2:0]       cfg;
    ctl_t             ctl;
    logic [N-1:0]     smp_q;
    logic [N-1:0]     out_view;
    logic             stat_q;
    logic             any_hit;
    logic             clr_wr;
    logic [BUS_W-1:0] rd_n;
    logic             unused_dat;

    assign wdat       = bus_wdata[N-1:0];
    assign unused_dat = ^bus_wdata;

    gpio_bus_decode #(
        .ADR_W       (ADR_W),
        .FULL_DECODE (FULL_DECODE)
    ) u_dec (
        .clk (clk),
        .rst (rst),
        .cyc (bus_cyc),
        .stb (bus_stb),
        .we  (bus_we),
        .adr (bus_adr),
        .sel (bus_sel),
        .op  (op),
        .ack (bus_ack),
        .err (bus_err)
    );

    // Pin-wide read/write registers, each present only if enabled
    generate
        for (genvar g = FIRST_RW; g <= LAST_RW; g++) begin : g_reg
            if (IMPL_MASK[g]) begin : g_on
                logic [N-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst)                                     q <= '0;
                    else if (op.wr && op.idx == reg_sel_e'(g))   q <= wdat;
                end
                assign dreg[g] = q;
            end else begin : g_off
                assign dreg[g] = '0;
            end
        end

        if (IMPL_MASK[RS_CTL]) begin : g_ctl_on
            logic [2:0] q;
            always_ff @(posedge clk) begin
                if (rst)                               q <= '0;
                else if (op.wr && op.idx == RS_CTL)    q <= bus_wdata[2:0];
            end
            assign cfg = q;
        end else begin : g_ctl_off
            assign cfg = '0;
        end
    endgenerate

    assign clr_wr = IMPL_MASK[RS_CTL] && op.wr && (op.idx == RS_CTL) && !bus_wdata[3];

    gpio_in_capture #(
        .N (N)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .ext_clk  (ext_clk),
        .ext_sel  (cfg[0]),
        .fall_sel (cfg[1]),
        .pin_i    (pin_i),
        .smp_q    (smp_q)
    );

    gpio_irq_gen #(
        .N (N)
    ) u_irq (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp_q),
        .ien     (dreg[RS_IEN]),
        .pol     (dreg[RS_POL]),
        .clr_wr  (clr_wr),
        .any_hit (any_hit),
        .stat_q  (stat_q)
    );

    assign ctl = '{stat: stat_q, irq_en: cfg[2], fall_sel: cfg[1], ext_sel: cfg[0]};

    always_comb begin
        rd_n = '0;
        case (op.idx)
            RS_IN:   if (IMPL_MASK[RS_IN])  rd_n[N-1:0] = smp_q;
            RS_OUT:  rd_n[N-1:0] = dreg[RS_OUT];
            RS_OE:   rd_n[N-1:0] = dreg[RS_OE];
            RS_IEN:  rd_n[N-1:0] = dreg[RS_IEN];
            RS_POL:  rd_n[N-1:0] = dreg[RS_POL];
            RS_ALT:  rd_n[N-1:0] = dreg[RS_ALT];
            RS_CTL:  if (IMPL_MASK[RS_CTL]) rd_n[3:0] = ctl;
            default: rd_n = '0;
        endcase
        if (!op.hit) rd_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)          bus_rdata <= '0;
        else if (op.take) bus_rdata <= rd_n;
    end

    assign out_view = dreg[RS_OUT];
    assign pin_o    = (dreg[RS_ALT] & aux_i) | (~dreg[RS_ALT] & out_view);
    assign pin_oe   = dreg[RS_OE];
    assign irq_o    = ctl.stat & ctl.irq_en;

endmodule

// File: rtl/gpio_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_ctrl_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cyc,
    input logic         stb,
    input logic [3:0]   sel,
    input logic         ack,
    input logic         err,
    input logic         inta,
    input logic [N-1:0] out_view,
    input logic         stat,
    input logic         any_hit,
    input logic         clr_wr
);

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_full_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !ack && !err && sel == 4'hF) |=> ack);

    p_narrow_err_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !ack && !err && sel != 4'hF) |=> err);

    p_resp_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(ack && err));

    p_err_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(out_view));

    p_stat_set_r8: assert property (@(posedge clk) disable iff (rst)
        any_hit |=> stat);

    p_stat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stat && !clr_wr) |=> stat);

    p_irq_needs_stat_r9: assert property (@(posedge clk) disable iff (rst)
        inta |-> stat);

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(NPINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc      (bus_cyc),
    .stb      (bus_stb),
    .sel      (bus_sel),
    .ack      (bus_ack),
    .err      (bus_err),
    .inta     (irq_o),
    .out_view (out_view),
    .stat     (stat_q),
    .any_hit  (any_hit),
    .clr_wr   (clr_wr)
);

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [7:0]  adr = '0;
    logic [3:0]  sel = '0;
    logic [31:0] wdata = '0;
    logic        ext_clk = 1'b0;
    logic [15:0] pin_i = '0, aux_i = '0;

    logic [31:0] rdata, rdata2;
    logic        ack, err, irq, ack2, err2, irq2;
    logic [15:0] pin_o, pin_oe;
    logic [7:0]  pin_o2, pin_oe2;

    always #5 clk = ~clk;

    gpio_ctrl dut (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_adr(adr), .bus_sel(sel), .bus_wdata(wdata), .bus_rdata(rdata),
        .bus_ack(ack), .bus_err(err), .irq_o(irq), .ext_clk(ext_clk),
        .aux_i(aux_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // Narrow, partially decoded instance without the alternate-select register
    gpio_ctrl #(.NPINS(8), .FULL_DECODE(1'b0), .IMPL_MASK(7'h5F)) dut2 (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_adr(adr), .bus_sel(sel), .bus_wdata(wdata), .bus_rdata(rdata2),
        .bus_ack(ack2), .bus_err(err2), .irq_o(irq2), .ext_clk(ext_clk),
        .aux_i(aux_i[7:0]), .pin_i(pin_i[7:0]), .pin_o(pin_o2), .pin_oe(pin_oe2)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference for dut ----------------
    logic [31:0] m_reg [0:6];
    logic        m_ack, m_err;
    logic [31:0] m_dat;
    logic [15:0] m_in, m_prev;
    logic        m_s1, m_s2, m_s3;
    logic        m_req, m_full, m_hit, m_wr, m_edge, m_irqhit, m_stat;
    logic [2:0]  m_off;
    logic [31:0] m_oldctl;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 7; i++) m_reg[i] = '0;
            m_ack = 0; m_err = 0; m_dat = '0;
            m_in = '0; m_prev = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_oldctl = m_reg[6];
            m_req  = cyc && stb && !m_ack && !m_err;
            m_full = (sel == 4'hF);
            m_off  = adr[4:2];
            m_hit  = (adr[7:5] == 0) && (adr[1:0] == 0) && (m_off != 3'd7);
            m_wr   = m_req && m_full && we && m_hit;
            m_edge = m_s2 && !m_s3;
            m_irqhit = 0;
            for (int i = 0; i < 16; i++) begin
                if (m_reg[3][i]) begin
                    if (m_reg[4][i] && m_in[i] && !m_prev[i]) m_irqhit = 1;
                    if (!m_reg[4][i] && !m_in[i] && m_prev[i]) m_irqhit = 1;
                end
            end
            if (m_req && m_full)
                m_dat = !m_hit ? 32'h0 : (m_off == 0 ? {16'h0, m_in} : m_reg[m_off]);
            m_ack = m_req && m_full;
            m_err = m_req && !m_full;
            m_stat = m_irqhit || (m_oldctl[3] && !(m_wr && m_off == 6 && !wdata[3]));
            if (m_wr && m_off == 6)      m_reg[6] = {29'h0, wdata[2:0]};
            else if (m_wr && m_off != 0) m_reg[m_off] = {16'h0, wdata[15:0]};
            m_reg[6][3] = m_stat;
            m_prev = m_in;
            if (!m_oldctl[0] || m_edge) m_in = pin_i;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = m_oldctl[1] ? !ext_clk : ext_clk;
        end
    end

    always @(posedge clk) begin
        #2;
        check("R5 ack vs model", {31'h0, ack}, {31'h0, m_ack});
        check("R4 err vs model", {31'h0, err}, {31'h0, m_err});
        check("R9 irq vs model", {31'h0, irq}, {31'h0, m_reg[6][3] & m_reg[6][2]});
        check("R10 pin_o vs model", {16'h0, pin_o},
              {16'h0, (m_reg[5][15:0] & aux_i) | (~m_reg[5][15:0] & m_reg[1][15:0])});
        check("R10 pin_oe vs model", {16'h0, pin_oe}, m_reg[2]);
        if (m_ack) check("R2 rdata vs model", rdata, m_dat);
    end

    // ---------------- stimulus ----------------
    logic [31:0] rd1, rd2;
    logic        got_ack, got_err;

    task automatic bus(input logic wr, input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = wr; adr = a; sel = s; wdata = d;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #1;
            if (ack || err) break;
        end
        rd1 = rdata; rd2 = rdata2; got_ack = ack; got_err = err;
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 0;
        // R12: everything reads zero after reset
        check("R12 irq after reset", {31'h0, irq}, 32'h0);
        check("R12 pin_o after reset", {16'h0, pin_o}, 32'h0);
        for (int r = 0; r < 7; r++) begin
            bus(0, 8'(r * 4), 4'hF, 0);
            check("R12 register zero after reset", rd1, 32'h0);
        end

        // R2 / R5: write and read back output data
        bus(1, 8'h04, 4'hF, 32'h0000A5A5);
        check("R5 write acknowledged", {31'h0, got_ack}, 32'h1);
        bus(0, 8'h04, 4'hF, 0);
        check("R2 output readback", rd1, 32'h0000A5A5);
        check("R2 narrow instance readback", rd2, 32'h000000A5);

        bus(1, 8'h08, 4'hF, 32'h00000F0F);
        check("R10 pin_oe follows register", {16'h0, pin_oe}, 32'h00000F0F);

        // R1: upper bits dropped
        bus(1, 8'h04, 4'hF, 32'hFFFFFFFF);
        bus(0, 8'h04, 4'hF, 0);
        check("R1 16-pin upper bits zero", rd1, 32'h0000FFFF);
        check("R1 8-pin upper bits zero", rd2, 32'h000000FF);

        // R10 / R11: alternate select
        aux_i = 16'h1234;
        bus(1, 8'h14, 4'hF, 32'h000000FF);
        idle(1);
        check("R10 pin_o mixes aux", {16'h0, pin_o}, 32'h0000FF34);
        bus(0, 8'h14, 4'hF, 0);
        check("R10 alt select readback", rd1, 32'h000000FF);
        check("R11 omitted register reads zero", rd2, 32'h0);
        check("R11 omitted alt leaves output data", {24'h0, pin_o2}, 32'h000000FF);

        // R4: narrow accesses
        bus(1, 8'h04, 4'h3, 32'h0);
        check("R4 narrow write gets err", {30'h0, got_err, got_ack}, 32'h2);
        bus(0, 8'h04, 4'hF, 0);
        check("R4 narrow write ignored", rd1, 32'h0000FFFF);
        bus(0, 8'h00, 4'h1, 0);
        check("R4 narrow read gets err", {30'h0, got_err, got_ack}, 32'h2);

        // R3: full versus partial decoding
        bus(1, 8'h24, 4'hF, 32'h1);
        check("R3 miss still acknowledged", {31'h0, got_ack}, 32'h1);
        bus(0, 8'h04, 4'hF, 0);
        check("R3 high address bit blocks write", rd1, 32'h0000FFFF);
        check("R3 partial decode accepts alias", rd2, 32'h1);
        bus(1, 8'h05, 4'hF, 32'h2);
        bus(0, 8'h04, 4'hF, 0);
        check("R3 byte offset blocks write", rd1, 32'h0000FFFF);
        check("R3 partial decode ignores offset", rd2, 32'h2);
        bus(0, 8'h24, 4'hF, 0);
        check("R3 miss reads zero", rd1, 32'h0);

        // R7: system-clock sampling
        pin_i = 16'h3C3C;
        idle(2);
        bus(0, 8'h00, 4'hF, 0);
        check("R7 input sampled on sysclk", rd1, 32'h00003C3C);
        check("R7 narrow instance input", rd2, 32'h3C);

        // R8 / R9 / R6: interrupts
        bus(1, 8'h0C, 4'hF, 32'h1);
        bus(1, 8'h10, 4'hF, 32'h1);
        bus(1, 8'h18, 4'hF, 32'h4);
        pin_i = 16'h3C3D;
        idle(4);
        check("R8 rising edge sets irq", {31'h0, irq}, 32'h1);
        bus(0, 8'h18, 4'hF, 0);
        check("R6 control bits status and enable", rd1, 32'hC);
        bus(1, 8'h18, 4'hF, 32'hC);
        idle(2);
        check("R8 writing one keeps status", {31'h0, irq}, 32'h1);
        bus(1, 8'h18, 4'hF, 32'h4);
        idle(2);
        check("R8 writing zero clears status", {31'h0, irq}, 32'h0);
        pin_i = 16'h3C3F;
        idle(4);
        check("R8 disabled pin no interrupt", {31'h0, irq}, 32'h0);
        bus(1, 8'h10, 4'hF, 32'h0);
        pin_i = 16'h3C3E;
        idle(4);
        check("R8 falling polarity sets irq", {31'h0, irq}, 32'h1);
        bus(1, 8'h18, 4'hF, 32'h0);
        pin_i = 16'h3C3F;
        idle(3);
        pin_i = 16'h3C3E;
        idle(4);
        check("R9 irq gated by enable", {31'h0, irq}, 32'h0);
        bus(0, 8'h18, 4'hF, 0);
        check("R9 status readable while gated", rd1, 32'h8);
        bus(1, 8'h18, 4'hF, 32'h0);

        // R7: external-clock capture
        bus(1, 8'h18, 4'hF, 32'h1);
        pin_i = 16'h0F0F;
        idle(5);
        bus(0, 8'h00, 4'hF, 0);
        check("R7 no capture without ext edge", rd1, 32'h00003C3E);
        ext_clk = 1;
        idle(5);
        ext_clk = 0;
        idle(3);
        bus(0, 8'h00, 4'hF, 0);
        check("R7 capture on rising ext edge", rd1, 32'h00000F0F);
        bus(1, 8'h18, 4'hF, 32'h3);
        idle(5);
        pin_i = 16'hF0F0;
        ext_clk = 1;
        idle(5);
        bus(0, 8'h00, 4'hF, 0);
        check("R7 rising edge ignored in falling mode", rd1, 32'h00000F0F);
        ext_clk = 0;
        idle(5);
        bus(0, 8'h00, 4'hF, 0);
        check("R7 capture on falling ext edge", rd1, 32'h0000F0F0);

        // R12: reset mid-run clears state
        rst = 1;
        idle(2);
        rst = 0;
        bus(0, 8'h04, 4'hF, 0);
        check("R12 reset clears output data", rd1, 32'h0);

        idle(3);
        finish_run();
    end

endmodule